// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between the register file and the data memory of a 32-bit core. It decodes load and store instructions in the I-type layout and forms the effective address as rs1 plus the sign-extended 16-bit immediate. On loads it picks the addressed byte, halfword or word out of the 32-bit memory word, extends it, and presents it for register write-back. On stores it steers the store value onto the right byte lanes and raises the matching byte enables. Memory reads are combinational: the read word must be valid in the same cycle as the address.

Byte, halfword, word and single-float accesses complete in the cycle the request is presented. A double-float access takes two consecutive cycles, one 32-bit beat each. The first beat goes to the even register of a pair at address A. The second goes to the odd register at A+4. During the second beat the unit is not ready and ignores any new request. Integer loads aimed at register 0 are dropped. Float loads are routed to the float register file, where register 0 is an ordinary register.

Top module: `ls_align_unit`

## Requirements
- R1: The instruction holds opcode in [31:26], rs1 in [25:21], rd in [20:16] and the immediate in [15:0]. Outside a second beat, mem_addr_o equals rs1_val_i plus the sign-extended immediate, with 32-bit wrap, in the same cycle.
- R2: Opcodes are LB=0x20, LH=0x21, LW=0x23, LBU=0x24, LHU=0x25, LF=0x26, LD=0x27, SB=0x28, SH=0x29, SW=0x2B, SF=0x2E and SD=0x2F. A load raises mem_re_o and a store raises mem_we_o, never both.
- R3: Byte lanes are big-endian: address bits [1:0]=0 selects data bits [31:24] and 3 selects [7:0]. LB sign-extends the selected byte and LBU zero-extends it.
- R4: For halfwords, address bit 1 = 0 selects bits [31:16] and 1 selects [15:0]. Address bit 0 is ignored. LH sign-extends the halfword and LHU zero-extends it.
- R5: LW and LF write the whole memory word regardless of address bits [1:0]. wb_fp_o is 1 for LF and LD and 0 for integer loads.
- R6: An integer load with rd = 0 leaves wb_we_o low. A float load with rd = 0 still writes.
- R7: A store never raises wb_we_o. SB replicates st_even_i[7:0] on all four lanes and sets the single mem_be_o bit (3 - addr[1:0]). SH replicates st_even_i[15:0] and sets 4'b1100 when address bit 1 is 0 and 4'b0011 otherwise. SW and SF drive st_even_i with enables 4'b1111.
- R8: A double access uses rd with bit 0 cleared in beat 0 at address A. In the next cycle it uses rd with bit 0 set at A+4, with ready_o low for exactly that cycle. SD sends st_even_i in beat 0 and, in beat 1, the st_odd_i value captured at beat 0.
- R9: An undefined opcode, or any request while ready_o is low, causes no memory access and no write-back. mem_be_o and mem_wdata_o are zero whenever mem_we_o is low.
- R10: In reset, and in the cycle reset is asserted during a double, ready_o is 1 and no access or write-back is driven without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Instruction valid this cycle |
| instr_i | input | 32 | Load/store instruction word |
| rs1_val_i | input | 32 | Base register value |
| st_even_i | input | 32 | Store data from rd (the even register for doubles) |
| st_odd_i | input | 32 | Store data from the odd register of a double pair |
| ready_o | output | 1 | Low during the second beat of a double |
| mem_addr_o | output | 32 | Byte address to memory |
| mem_re_o | output | 1 | Memory read |
| mem_we_o | output | 1 | Memory write |
| mem_be_o | output | 4 | Byte enables, bit 3 = bits [31:24] |
| mem_wdata_o | output | 32 | Write data, lane-steered |
| mem_rdata_i | input | 32 | Read word, valid in the same cycle |
| wb_we_o | output | 1 | Register write-back enable |
| wb_fp_o | output | 1 | Write-back targets the float register file |
| wb_rd_o | output | 5 | Write-back register index |
| wb_data_o | output | 32 | Extended load data |

## Verification
The hardest state to reach from the ports is the second beat of a double. Its outputs come from registers captured one cycle earlier, so a fault there stays hidden unless the live inputs disagree with the captured ones. The stimulus changes st_odd_i and presents a competing store request during the second beat, then checks that the odd data, address and register index still come from the accepted double. Reset is also asserted in the middle of a double to show that the pending beat is dropped.

// File: rtl/ls_align_pkg.sv
package ls_align_pkg;
  localparam int XLEN  = 32;
  localparam int IMM_W = 16;
  localparam int REG_W = 5;
  localparam int OP_W  = 6;

  typedef enum logic [OP_W-1:0] {
    OP_LB  = 6'h20, OP_LH  = 6'h21, OP_LW  = 6'h23, OP_LBU = 6'h24,
    OP_LHU = 6'h25, OP_LF  = 6'h26, OP_LD  = 6'h27, OP_SB  = 6'h28,
    OP_SH  = 6'h29, OP_SW  = 6'h2B, OP_SF  = 6'h2E, OP_SD  = 6'h2F
  } ls_op_e;

  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W, SZ_D} ls_size_e;

  typedef struct packed {
    logic     valid;
    logic     store;
    logic     uns;
    logic     fp;
    ls_size_e size;
  } ls_ctrl_t;
endpackage

// File: rtl/ls_decode.sv
module ls_decode
  import ls_align_pkg::*;
(
  input  logic [XLEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  base_i,
  output ls_ctrl_t         ctrl_o,
  output logic [REG_W-1:0] rd_o,
  output logic [XLEN-1:0]  ea_o
);
  localparam int OP_LSB  = XLEN - OP_W;
  localparam int RD_LSB  = IMM_W;

  logic [OP_W-1:0] op;
  logic [IMM_W-1:0] imm;

  assign op   = instr_i[XLEN-1:OP_LSB];
  assign rd_o = instr_i[RD_LSB+REG_W-1:RD_LSB];
  assign imm  = instr_i[IMM_W-1:0];
  assign ea_o = base_i + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    ctrl_o = '{valid: 1'b1, store: 1'b0, uns: 1'b0, fp: 1'b0, size: SZ_W};
    unique case (op)
      OP_LB:  ctrl_o.size = SZ_B;
      OP_LBU: begin ctrl_o.size = SZ_B; ctrl_o.uns = 1'b1; end
      OP_LH:  ctrl_o.size = SZ_H;
      OP_LHU: begin ctrl_o.size = SZ_H; ctrl_o.uns = 1'b1; end
      OP_LW:  ctrl_o.size = SZ_W;
      OP_LF:  ctrl_o.fp = 1'b1;
      OP_LD:  begin ctrl_o.size = SZ_D; ctrl_o.fp = 1'b1; end
      OP_SB:  begin ctrl_o.size = SZ_B; ctrl_o.store = 1'b1; end
      OP_SH:  begin ctrl_o.size = SZ_H; ctrl_o.store = 1'b1; end
      OP_SW:  ctrl_o.store = 1'b1;
      OP_SF:  begin ctrl_o.store = 1'b1; ctrl_o.fp = 1'b1; end
      OP_SD:  begin ctrl_o.size = SZ_D; ctrl_o.store = 1'b1; ctrl_o.fp = 1'b1; end
      default: ctrl_o.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/ls_load_align.sv
module ls_load_align
  import ls_align_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0]             rdata_i,
  input  ls_size_e                 size_i,
  input  logic                     uns_i,
  input  logic [$clog2(W/8)-1:0]   lane_i,
  output logic [W-1:0]             data_o
);
  localparam int NB = W / 8;
  localparam int LW = $clog2(NB);

  logic [LW-1:0] inv_lane;
  logic [7:0]    byte_v;
  logic [15:0]   half_v;

  // big-endian: lane 0 is the most significant byte
  assign inv_lane = ~lane_i;
  assign byte_v   = 8'(rdata_i >> {inv_lane, 3'b000});
  assign half_v   = 16'(rdata_i >> {inv_lane[LW-1:1], 4'b0000});

  always_comb begin
    unique case (size_i)
      SZ_B:    data_o = {{(W-8){~uns_i & byte_v[7]}}, byte_v};
      SZ_H:    data_o = {{(W-16){~uns_i & half_v[15]}}, half_v};
      default: data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/ls_store_align.sv
module ls_store_align
  import ls_align_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic                     en_i,
  input  logic [W-1:0]             data_i,
  input  ls_size_e                 size_i,
  input  logic [$clog2(W/8)-1:0]   lane_i,
  output logic [W-1:0]             wdata_o,
  output logic [W/8-1:0]           be_o
);
  localparam int NB = W / 8;
  localparam int LW = $clog2(NB);

  always_comb begin
    if (!en_i)                wdata_o = '0;
    else if (size_i == SZ_B)  wdata_o = {NB{data_i[7:0]}};
    else if (size_i == SZ_H)  wdata_o = {(NB/2){data_i[15:0]}};
    else                      wdata_o = data_i;
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [LW-1:0] POS = LW'(NB - 1 - i);
    logic hit;
    always_comb begin
      unique case (size_i)
        SZ_B:    hit = (lane_i == POS);
        SZ_H:    hit = (lane_i[LW-1] == POS[LW-1]);
        default: hit = 1'b1;
      endcase
    end
    assign be_o[i] = en_i & hit;
  end
endmodule

// File: rtl/ls_align_unit.sv
module ls_align_unit
  import ls_align_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] rs1_val_i,
  input  logic [31:0] st_even_i,
  input  logic [31:0] st_odd_i,
  output logic        ready_o,
  output logic [31:0] mem_addr_o,
  output logic        mem_re_o,
  output logic        mem_we_o,
  output logic [3:0]  mem_be_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  output logic        wb_we_o,
  output logic        wb_fp_o,
  output logic [4:0]  wb_rd_o,
  output logic [31:0] wb_data_o
);
  localparam int NB = XLEN / 8;
  localparam int LW = $clog2(NB);

  ls_ctrl_t         ctrl;
  logic [REG_W-1:0] rd;
  logic [XLEN-1:0]  ea;
  logic [XLEN-1:0]  ld_data;
  logic [XLEN-1:0]  st_data;
  logic [NB-1:0]    st_be;
  logic             live;
  logic             st_live;
  logic             is_dbl;

  logic             beat1_q;
  logic             store_q;
  logic [XLEN-1:0]  addr_q;
  logic [XLEN-1:0]  odd_q;
  logic [REG_W-1:0] rd_q;

  ls_decode u_dec (
    .instr_i (instr_i),
    .base_i  (rs1_val_i),
    .ctrl_o  (ctrl),
    .rd_o    (rd),
    .ea_o    (ea)
  );

  assign live    = req_i & ~beat1_q & ctrl.valid;
  assign st_live = live & ctrl.store;
  assign is_dbl  = ctrl.size == SZ_D;

  ls_load_align #(.W(XLEN)) u_ld (
    .rdata_i (mem_rdata_i),
    .size_i  (ctrl.size),
    .uns_i   (ctrl.uns),
    .lane_i  (ea[LW-1:0]),
    .data_o  (ld_data)
  );

  ls_store_align #(.W(XLEN)) u_st (
    .en_i    (st_live),
    .data_i  (st_even_i),
    .size_i  (ctrl.size),
    .lane_i  (ea[LW-1:0]),
    .wdata_o (st_data),
    .be_o    (st_be)
  );

  // second beat of a double: state captured at beat 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat1_q <= 1'b0;
      store_q <= 1'b0;
      addr_q  <= '0;
      odd_q   <= '0;
      rd_q    <= '0;
    end else begin
      beat1_q <= live & is_dbl;
      if (live & is_dbl) begin
        store_q <= ctrl.store;
        addr_q  <= ea + XLEN'(NB);
        odd_q   <= st_odd_i;
        rd_q    <= {rd[REG_W-1:1], 1'b1};
      end
    end
  end

  assign ready_o = ~beat1_q;

  always_comb begin
    if (beat1_q) begin
      mem_addr_o  = addr_q;
      mem_re_o    = ~store_q;
      mem_we_o    = store_q;
      mem_be_o    = {NB{store_q}};
      mem_wdata_o = store_q ? odd_q : '0;
      wb_we_o     = ~store_q;
      wb_fp_o     = 1'b1;
      wb_rd_o     = rd_q;
      wb_data_o   = mem_rdata_i;
    end else begin
      mem_addr_o  = ea;
      mem_re_o    = live & ~ctrl.store;
      mem_we_o    = st_live;
      mem_be_o    = st_be;
      mem_wdata_o = st_data;
      wb_we_o     = live & ~ctrl.store & (ctrl.fp | (rd != '0));
      wb_fp_o     = ctrl.fp;
      wb_rd_o     = is_dbl ? {rd[REG_W-1:1], 1'b0} : rd;
      wb_data_o   = ld_data;
    end
  end

  assert_r0_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_we_o && !wb_fp_o) |-> (wb_rd_o != '0));

  assert_one_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  assert_be_shape_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2
                  || $countones(mem_be_o) == 4));

  assert_idle_lanes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_o |-> (mem_be_o == '0 && mem_wdata_o == '0));

  assert_beat1_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (mem_addr_o == $past(mem_addr_o) + 32'd4));

  assert_beat1_reg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && wb_we_o) |-> (wb_rd_o == ($past(wb_rd_o) | 5'd1)));

  assert_one_beat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o);
endmodule

// File: tb/ls_align_unit_bench.sv
module ls_align_unit_bench;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] instr_i = '0, rs1_val_i = '0, st_even_i = '0, st_odd_i = '0;
  logic        ready_o, mem_re_o, mem_we_o, wb_we_o, wb_fp_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, wb_data_o;
  logic [3:0]  mem_be_o;
  logic [4:0]  wb_rd_o;

  logic [31:0] mem [16];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  assign mem_rdata_i = mem[mem_addr_o[5:2]];

  ls_align_unit u_ls_align_unit (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .instr_i(instr_i),
    .rs1_val_i(rs1_val_i), .st_even_i(st_even_i), .st_odd_i(st_odd_i),
    .ready_o(ready_o), .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o),
    .mem_we_o(mem_we_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .wb_we_o(wb_we_o), .wb_fp_o(wb_fp_o),
    .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [4:0]  rd;
    logic [15:0] imm;
    logic [31:0] rs1;
    logic [31:0] addr;
    logic        re;
    logic        we;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic        wbwe;
    logic        wbfp;
    logic [4:0]  wbrd;
    logic [31:0] wbdata;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  // memory word 1 (bytes 4..7) = 8C 35 F1 7E; st_even_i = A1B2C3D4
  localparam vec_t VECS [NV] = '{
    '{6'h20, 5'd3, 16'hFFF4, 32'h10, 32'h4, 1, 0, 4'h0, 32'h0, 1, 0, 5'd3, 32'hFFFFFF8C, 4'd3}, // R3
    '{6'h24, 5'd3, 16'hFFF5, 32'h10, 32'h5, 1, 0, 4'h0, 32'h0, 1, 0, 5'd3, 32'h00000035, 4'd3}, // R3
    '{6'h20, 5'd3, 16'hFFF6, 32'h10, 32'h6, 1, 0, 4'h0, 32'h0, 1, 0, 5'd3, 32'hFFFFFFF1, 4'd3}, // R3
    '{6'h24, 5'd3, 16'hFFF6, 32'h10, 32'h6, 1, 0, 4'h0, 32'h0, 1, 0, 5'd3, 32'h000000F1, 4'd3}, // R3
    '{6'h24, 5'd3, 16'h000C, 32'hFFFFFFF8, 32'h4, 1, 0, 4'h0, 32'h0, 1, 0, 5'd3, 32'h0000008C, 4'd1}, // R1 wrap
    '{6'h21, 5'd4, 16'hFFF4, 32'h10, 32'h4, 1, 0, 4'h0, 32'h0, 1, 0, 5'd4, 32'hFFFF8C35, 4'd4}, // R4
    '{6'h25, 5'd4, 16'hFFF6, 32'h10, 32'h6, 1, 0, 4'h0, 32'h0, 1, 0, 5'd4, 32'h0000F17E, 4'd4}, // R4
    '{6'h21, 5'd4, 16'hFFF7, 32'h10, 32'h7, 1, 0, 4'h0, 32'h0, 1, 0, 5'd4, 32'hFFFFF17E, 4'd4}, // R4
    '{6'h25, 5'd4, 16'hFFF5, 32'h10, 32'h5, 1, 0, 4'h0, 32'h0, 1, 0, 5'd4, 32'h00008C35, 4'd4}, // R4
    '{6'h23, 5'd9, 16'hFFF5, 32'h10, 32'h5, 1, 0, 4'h0, 32'h0, 1, 0, 5'd9, 32'h8C35F17E, 4'd5}, // R5
    '{6'h23, 5'd7, 16'h0004, 32'h4,  32'h8, 1, 0, 4'h0, 32'h0, 1, 0, 5'd7, 32'h13579BDF, 4'd1}, // R1
    '{6'h26, 5'd0, 16'hFFF4, 32'h10, 32'h4, 1, 0, 4'h0, 32'h0, 1, 1, 5'd0, 32'h8C35F17E, 4'd6}, // R6 fp F0
    '{6'h23, 5'd0, 16'hFFF4, 32'h10, 32'h4, 1, 0, 4'h0, 32'h0, 0, 0, 5'd0, 32'h0, 4'd6}, // R6
    '{6'h20, 5'd0, 16'hFFF7, 32'h10, 32'h7, 1, 0, 4'h0, 32'h0, 0, 0, 5'd0, 32'h0, 4'd6}, // R6
    '{6'h28, 5'd2, 16'hFFF4, 32'h10, 32'h4, 0, 1, 4'h8, 32'hD4D4D4D4, 0, 0, 5'd0, 32'h0, 4'd7}, // R7
    '{6'h28, 5'd2, 16'hFFF7, 32'h10, 32'h7, 0, 1, 4'h1, 32'hD4D4D4D4, 0, 0, 5'd0, 32'h0, 4'd7}, // R7
    '{6'h28, 5'd2, 16'hFFF5, 32'h10, 32'h5, 0, 1, 4'h4, 32'hD4D4D4D4, 0, 0, 5'd0, 32'h0, 4'd7}, // R7
    '{6'h29, 5'd2, 16'hFFF6, 32'h10, 32'h6, 0, 1, 4'h3, 32'hC3D4C3D4, 0, 0, 5'd0, 32'h0, 4'd7}, // R7
    '{6'h29, 5'd2, 16'hFFF4, 32'h10, 32'h4, 0, 1, 4'hC, 32'hC3D4C3D4, 0, 0, 5'd0, 32'h0, 4'd7}, // R7
    '{6'h2B, 5'd2, 16'hFFF5, 32'h10, 32'h5, 0, 1, 4'hF, 32'hA1B2C3D4, 0, 0, 5'd0, 32'h0, 4'd7}, // R7
    '{6'h2E, 5'd2, 16'hFFF4, 32'h10, 32'h4, 0, 1, 4'hF, 32'hA1B2C3D4, 0, 0, 5'd0, 32'h0, 4'd2}, // R2
    '{6'h3F, 5'd3, 16'hFFF4, 32'h10, 32'h4, 0, 0, 4'h0, 32'h0, 0, 0, 5'd0, 32'h0, 4'd9}, // R9
    '{6'h22, 5'd3, 16'hFFF4, 32'h10, 32'h4, 0, 0, 4'h0, 32'h0, 0, 0, 5'd0, 32'h0, 4'd9}  // R9
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic put(input logic [5:0] op, input logic [4:0] rd, input logic [15:0] imm,
                     input logic [31:0] rs1);
    instr_i   = {op, 5'd1, rd, imm};
    rs1_val_i = rs1;
    req_i     = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    mem[1] = 32'h8C35F17E;
    mem[2] = 32'h13579BDF;
    mem[3] = 32'h2468ACE0;
    st_even_i = 32'hA1B2C3D4;

    // reset state, R10
    repeat (2) @(negedge clk);
    #1;
    chk("R10 ready in reset", 32'(ready_o), 32'd1);
    chk("R10 no read in reset", 32'(mem_re_o), 32'd0);
    chk("R10 no write in reset", 32'(mem_we_o | wb_we_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // single-beat table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      put(VECS[i].op, VECS[i].rd, VECS[i].imm, VECS[i].rs1);
      #2;
      chk($sformatf("R%0d v%0d addr", VECS[i].req, i), mem_addr_o, VECS[i].addr);
      chk($sformatf("R%0d v%0d re", VECS[i].req, i), 32'(mem_re_o), 32'(VECS[i].re));
      chk($sformatf("R%0d v%0d we", VECS[i].req, i), 32'(mem_we_o), 32'(VECS[i].we));
      chk($sformatf("R%0d v%0d be", VECS[i].req, i), 32'(mem_be_o), 32'(VECS[i].be));
      chk($sformatf("R%0d v%0d wdata", VECS[i].req, i), mem_wdata_o, VECS[i].wdata);
      chk($sformatf("R%0d v%0d wb_we", VECS[i].req, i), 32'(wb_we_o), 32'(VECS[i].wbwe));
      chk($sformatf("R%0d v%0d ready", VECS[i].req, i), 32'(ready_o), 32'd1);
      if (VECS[i].wbwe) begin
        chk($sformatf("R%0d v%0d wb_fp", VECS[i].req, i), 32'(wb_fp_o), 32'(VECS[i].wbfp));
        chk($sformatf("R%0d v%0d wb_rd", VECS[i].req, i), 32'(wb_rd_o), 32'(VECS[i].wbrd));
        chk($sformatf("R%0d v%0d wb_data", VECS[i].req, i), wb_data_o, VECS[i].wbdata);
      end
    end

    // LD to odd rd 5: pair 4/5 at 8 and 12, R8
    @(negedge clk);
    put(6'h27, 5'd5, 16'h0008, 32'h0);
    #2;
    chk("R8 LD beat0 addr", mem_addr_o, 32'h8);
    chk("R8 LD beat0 rd", 32'(wb_rd_o), 32'd4);
    chk("R8 LD beat0 fp", 32'(wb_fp_o & wb_we_o), 32'd1);
    chk("R8 LD beat0 data", wb_data_o, 32'h13579BDF);
    @(negedge clk);
    put(6'h28, 5'd2, 16'hFFF4, 32'h10); // R9: must be ignored in beat 1
    #2;
    chk("R8 LD beat1 ready", 32'(ready_o), 32'd0);
    chk("R8 LD beat1 addr", mem_addr_o, 32'hC);
    chk("R9 LD beat1 no store", 32'(mem_we_o), 32'd0);
    chk("R8 LD beat1 rd", 32'(wb_rd_o), 32'd5);
    chk("R8 LD beat1 data", wb_data_o, 32'h2468ACE0);
    @(negedge clk);
    req_i = 1'b0;
    #2;
    chk("R8 ready after beat1", 32'(ready_o), 32'd1);
    chk("R9 dropped request left no access", 32'(mem_we_o | mem_re_o), 32'd0);

    // SD rd 3 -> pair 2/3, odd data captured at beat 0, R8
    @(negedge clk);
    st_even_i = 32'h11112222;
    st_odd_i  = 32'h33334444;
    put(6'h2F, 5'd3, 16'h0008, 32'h0);
    #2;
    chk("R8 SD beat0 wdata", mem_wdata_o, 32'h11112222);
    chk("R8 SD beat0 be", 32'(mem_be_o), 32'hF);
    chk("R8 SD beat0 no wb", 32'(wb_we_o), 32'd0);
    @(negedge clk);
    req_i    = 1'b0;
    st_odd_i = 32'hFFFFFFFF;
    #2;
    chk("R8 SD beat1 addr", mem_addr_o, 32'hC);
    chk("R8 SD beat1 wdata", mem_wdata_o, 32'h33334444);
    chk("R8 SD beat1 we", 32'(mem_we_o), 32'd1);
    chk("R8 SD beat1 ready", 32'(ready_o), 32'd0);

    // reset during beat 1, R10
    @(negedge clk);
    put(6'h27, 5'd2, 16'h0008, 32'h0);
    @(negedge clk);
    req_i = 1'b0;
    #1;
    chk("R10 beat1 pending before reset", 32'(ready_o), 32'd0);
    rst_ni = 1'b0;
    #1;
    chk("R10 reset clears beat1", 32'(ready_o), 32'd1);
    chk("R10 no access after reset", 32'(mem_re_o | wb_we_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 idle after reset", 32'(ready_o), 32'd1);

    finish_run();
  end
endmodule